// File: doc/BRIEF.md
# Return Address Stack

This block keeps the return addresses that a small processor core needs for nested subroutine calls and interrupt entry. A call or an interrupt pulses the push strobe together with the address to resume at. A return pulses the pop strobe, and one clock later the block presents the most recently stored address that has not yet been popped. The stack holds eight levels of 11-bit program counter values.

Software can read a level pointer that starts at all ones and counts down as the stack fills. The pointer sits in the low bits of an 8-bit status word. The top bit of that word is a global interrupt enable flag, which has its own write strobe and does not affect the stack. A push on a full stack is refused and raises a sticky overflow flag.

All state, including the stored entries, is cleared by a synchronous active-high reset.

Top module: `ret_stack_top`

## Requirements
- R1: After reset the pointer reads 3'b111, the overflow flag is 0, the popped-address output is 0 and the whole status word reads 8'h07.
- R2: The pointer equals 8 minus the number of stored levels, and reads 3'b111 both when the stack is empty and when it holds one level. A lone push on a non-full stack therefore leaves the pointer at 3'b111 when the stack was empty, and lowers it by one otherwise.
- R3: A lone pop on a non-empty stack drives the address of the latest unpopped push onto the popped-address output on the next clock, in strict last-in-first-out order.
- R4: A lone pop raises the pointer by one when two or more levels are stored. It leaves the pointer at 3'b111 when one level is stored, and that pop empties the stack.
- R5: A lone push on a stack that holds eight levels (pointer 3'b000) sets the overflow flag, leaves the pointer at 3'b000 and stores nothing. The eighth entry is still the next one popped.
- R6: The overflow flag stays at 1 until reset, whatever later pushes and pops occur.
- R7: A lone pop on an empty stack returns the value currently held in the level-1 slot (the last address stored at level 1, or 0 after reset) and leaves the pointer at 3'b111.
- R8: When push and pop are asserted in the same cycle, the old top address is popped, the new address takes its place and the pointer is unchanged. This never sets the overflow flag. On an empty stack the new address replaces the level-1 slot.
- R9: Status word bit 7 is the interrupt enable. It loads the enable data input when the enable write strobe is 1 and is otherwise held. Bits 2:0 are the pointer and bits 6:3 read 0. Enable writes never move the pointer, and pushes and pops never change bit 7.
- R10: The popped-address output changes only on a clock at which pop was asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Push strobe (call or interrupt entry) |
| push_addr_i | input | 11 | Return address to store |
| pop_i | input | 1 | Pop strobe (return) |
| gie_we_i | input | 1 | Write strobe for the interrupt enable bit |
| gie_d_i | input | 1 | New interrupt enable value |
| pop_addr_o | output | 11 | Address returned by the last pop |
| stk_ptr_o | output | 3 | Level pointer |
| stk_reg_o | output | 8 | Status word: enable in bit 7, pointer in bits 2:0 |
| ovf_err_o | output | 1 | Sticky overflow flag |

## Verification
A push and a pop can arrive in the same clock. The block must then read the old top and overwrite that same slot, while the pointer stays where it is. The bench provokes this on an empty stack, on a one-level stack, part way up and on a full stack where a lone push would overflow. A queue-based model predicts the popped value, the pointer and the flag for every cycle.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;

  // Slot that holds the current top level; an empty stack reports the level-1 slot.
  function automatic int top_slot(input int depth, input int levels);
    return (depth == 0) ? (levels - 1) : (levels - depth);
  endfunction

  // Slot that the next accepted push fills.
  function automatic int push_slot(input int depth, input int levels);
    return levels - 1 - depth;
  endfunction

endpackage

// File: rtl/ret_stack_ctrl.sv
module ret_stack_ctrl #(
  parameter int DEPTH = 8,
  parameter int PTR_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] ptr,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_slot,
  output logic [PTR_W-1:0] rd_slot,
  output logic             err_q
);
  import ret_stack_pkg::*;

  logic [CNT_W-1:0] depth_q;
  logic full, empty;
  logic ev_push, ev_ovf, ev_pop, ev_swap;

  assign full    = (depth_q == CNT_W'(DEPTH));
  assign empty   = (depth_q == '0);
  assign ev_swap = push && pop;
  assign ev_push = push && !pop && !full;
  assign ev_ovf  = push && !pop && full;
  assign ev_pop  = pop && !push && !empty;

  assign ptr     = PTR_W'(top_slot(int'(depth_q), DEPTH));
  assign rd_slot = ptr;
  assign wr_en   = ev_push || ev_swap;
  assign wr_slot = ev_swap ? ptr : PTR_W'(push_slot(int'(depth_q), DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      depth_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (ev_push)     depth_q <= depth_q + 1'b1;
      else if (ev_pop) depth_q <= depth_q - 1'b1;
      if (ev_ovf)      err_q   <= 1'b1;
    end
  end

  // R2: a push on a stack holding at least one level moves the pointer down by one
  a_r2_push_down: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !full && !empty) |=> (ptr == $past(ptr) - 1'b1));
  // R2: the first push keeps the pointer at all ones
  a_r2_first_push: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && empty) |=> (ptr == '1));
  // R4: a pop with two or more levels moves the pointer up by one
  a_r4_pop_up: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !empty && (ptr != '1)) |=> (ptr == $past(ptr) + 1'b1));
  // R5: an overflowing push pins the pointer at zero and raises the flag
  a_r5_ovf_pin: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && full) |=> (err_q && (ptr == '0)));
  // R6: the overflow flag is sticky
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
  // R8: a simultaneous push and pop keeps the pointer
  a_r8_swap_keep: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> $stable(ptr));
  // R8: a simultaneous push and pop never raises the flag
  a_r8_swap_no_err: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !err_q) |=> !err_q);

endmodule

// File: rtl/ret_stack_mem.sv
module ret_stack_mem #(
  parameter int DEPTH = 8,
  parameter int AW    = 11,
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_slot,
  input  logic [AW-1:0]    wr_data,
  input  logic [PTR_W-1:0] rd_slot,
  output logic [AW-1:0]    rd_data
);
  logic [AW-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                                    slot_q[g] <= '0;
      else if (wr_en && (wr_slot == PTR_W'(g)))   slot_q[g] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_slot];

  // R5: nothing is written at a slot index outside the stack
  a_r5_slot_range: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_slot) < DEPTH));

endmodule

// File: rtl/ret_stack_sreg.sv
module ret_stack_sreg #(
  parameter int AW      = 11,
  parameter int PTR_W   = 3,
  parameter int REG_W   = 8,
  parameter int GIE_BIT = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gie_we,
  input  logic             gie_d,
  input  logic [PTR_W-1:0] ptr,
  input  logic             pop_en,
  input  logic [AW-1:0]    pop_data,
  output logic [AW-1:0]    pop_addr_q,
  output logic [REG_W-1:0] reg_o
);
  logic gie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q      <= 1'b0;
      pop_addr_q <= '0;
    end else begin
      if (gie_we) gie_q      <= gie_d;
      if (pop_en) pop_addr_q <= pop_data;
    end
  end

  always_comb begin
    reg_o              = '0;
    reg_o[PTR_W-1:0]   = ptr;
    reg_o[GIE_BIT]     = gie_q;
  end

  // R9: the enable bit only changes on its own strobe
  a_r9_gie_hold: assert property (@(posedge clk) disable iff (rst)
    !gie_we |=> $stable(gie_q));
  // R10: the popped address only changes on a pop
  a_r10_pop_hold: assert property (@(posedge clk) disable iff (rst)
    !pop_en |=> $stable(pop_addr_q));

endmodule

// File: rtl/ret_stack_top.sv
module ret_stack_top #(
  parameter int DEPTH   = 8,
  parameter int AW      = 11,
  parameter int REG_W   = 8,
  parameter int GIE_BIT = 7
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push_i,
  input  logic [AW-1:0]              push_addr_i,
  input  logic                       pop_i,
  input  logic                       gie_we_i,
  input  logic                       gie_d_i,
  output logic [AW-1:0]              pop_addr_o,
  output logic [$clog2(DEPTH)-1:0]   stk_ptr_o,
  output logic [REG_W-1:0]           stk_reg_o,
  output logic                       ovf_err_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             wr_en;
  logic [PTR_W-1:0] wr_slot, rd_slot, ptr;
  logic [AW-1:0]    rd_data;

  ret_stack_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .push(push_i), .pop(pop_i), .ptr(ptr),
    .wr_en(wr_en), .wr_slot(wr_slot), .rd_slot(rd_slot), .err_q(ovf_err_o)
  );

  ret_stack_mem #(.DEPTH(DEPTH), .AW(AW), .PTR_W(PTR_W)) u_mem (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_data(push_addr_i), .rd_slot(rd_slot), .rd_data(rd_data)
  );

  ret_stack_sreg #(.AW(AW), .PTR_W(PTR_W), .REG_W(REG_W), .GIE_BIT(GIE_BIT)) u_sreg (
    .clk(clk), .rst(rst), .gie_we(gie_we_i), .gie_d(gie_d_i), .ptr(ptr),
    .pop_en(pop_i), .pop_data(rd_data), .pop_addr_q(pop_addr_o), .reg_o(stk_reg_o)
  );

  assign stk_ptr_o = ptr;

  // R1: the pointer reads all ones right after reset
  a_r1_reset_ptr: assert property (@(posedge clk)
    $past(rst) |-> (stk_ptr_o == '1 && !ovf_err_o));
  // R9: the pointer field of the status word mirrors the pointer output
  a_r9_reg_ptr: assert property (@(posedge clk) disable iff (rst)
    gie_we_i |=> (stk_reg_o[PTR_W-1:0] == $past(stk_ptr_o) || $past(push_i || pop_i)));

endmodule

// File: tb/ret_stack_top_bench.sv
`timescale 1ns/1ps
module ret_stack_top_bench;
  logic        clk = 1'b0;
  logic        rst, push_i, pop_i, gie_we_i, gie_d_i;
  logic [10:0] push_addr_i;
  logic [10:0] pop_addr_o;
  logic [2:0]  stk_ptr_o;
  logic [7:0]  stk_reg_o;
  logic        ovf_err_o;

  int checks = 0;
  int errors = 0;

  int          mq[$];
  logic [10:0] m_lvl1, m_pop;
  bit          m_err, m_gie;

  always #10 clk = ~clk;

  ret_stack_top u_ret_stack_top (
    .clk(clk), .rst(rst), .push_i(push_i), .push_addr_i(push_addr_i),
    .pop_i(pop_i), .gie_we_i(gie_we_i), .gie_d_i(gie_d_i),
    .pop_addr_o(pop_addr_o), .stk_ptr_o(stk_ptr_o), .stk_reg_o(stk_reg_o),
    .ovf_err_o(ovf_err_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_ptr();
    return (mq.size() == 0) ? 7 : 8 - mq.size();
  endfunction

  task automatic compare_all(input string req);
    chk(req, "pointer", int'(stk_ptr_o), exp_ptr());
    chk(req, "popped address", int'(pop_addr_o), int'(m_pop));
    chk(req, "overflow flag", int'(ovf_err_o), int'(m_err));
    chk(req, "status word", int'(stk_reg_o), (int'(m_gie) << 7) | exp_ptr());
  endtask

  task automatic model_step(input bit ps, input logic [10:0] a, input bit pp,
                            input bit gw, input bit gd);
    if (ps && pp) begin
      if (mq.size() == 0) begin
        m_pop  = m_lvl1;
        m_lvl1 = a;
      end else begin
        m_pop = 11'(mq[mq.size()-1]);
        mq[mq.size()-1] = int'(a);
        if (mq.size() == 1) m_lvl1 = a;
      end
    end else if (ps) begin
      if (mq.size() == 8) m_err = 1'b1;
      else begin
        mq.push_back(int'(a));
        if (mq.size() == 1) m_lvl1 = a;
      end
    end else if (pp) begin
      if (mq.size() == 0) m_pop = m_lvl1;
      else m_pop = 11'(mq.pop_back());
    end
    if (gw) m_gie = gd;
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic step(input bit ps, input logic [10:0] a, input bit pp,
                      input bit gw, input bit gd, input string req);
    push_i = ps; push_addr_i = a; pop_i = pp; gie_we_i = gw; gie_d_i = gd;
    @(posedge clk);
    model_step(ps, a, pp, gw, gd);
    #2;
    compare_all(req);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; push_i = 0; pop_i = 0; gie_we_i = 0; gie_d_i = 0; push_addr_i = '0;
    @(posedge clk);
    mq.delete(); m_lvl1 = '0; m_pop = '0; m_err = 0; m_gie = 0;
    @(negedge clk);
    rst = 1'b0;
    compare_all("R1");
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rst = 1'b1; push_i = 0; pop_i = 0; gie_we_i = 0; gie_d_i = 0; push_addr_i = '0;
    @(negedge clk);
    do_reset();                                       // R1

    step(0, 11'h000, 1, 0, 0, "R7");                  // R7 empty pop after reset
    step(1, 11'h101, 0, 0, 0, "R2");                  // R2 first push keeps 111
    step(1, 11'h202, 0, 0, 0, "R2");
    step(0, 11'h000, 0, 0, 0, "R10");                 // R10 idle hold
    step(0, 11'h000, 1, 0, 0, "R3");                  // R3 pops 202
    step(0, 11'h000, 1, 0, 0, "R4");                  // R4 last level, pointer stays
    step(0, 11'h000, 1, 0, 0, "R7");                  // R7 returns level-1 slot 101

    for (int i = 0; i < 8; i++) step(1, 11'(16'h310 + i), 0, 0, 0, "R2");
    step(1, 11'h7AA, 1, 0, 0, "R8");                  // R8 swap on full stack
    step(1, 11'h555, 0, 0, 0, "R5");                  // R5 ninth push
    step(1, 11'h556, 0, 1, 1, "R9");                  // R9 enable write during overflow
    step(0, 11'h000, 1, 0, 0, "R5");                  // R5 top kept: 7AA
    for (int i = 0; i < 7; i++) step(0, 11'h000, 1, 0, 0, "R3");
    step(0, 11'h000, 1, 0, 0, "R6");                  // R6 flag still set
    step(1, 11'h0C3, 1, 0, 0, "R8");                  // R8 swap on empty stack
    step(0, 11'h000, 1, 0, 0, "R8");                  // level-1 slot now 0C3
    step(1, 11'h041, 0, 1, 0, "R9");
    step(1, 11'h042, 1, 0, 0, "R8");                  // R8 swap with one level
    step(0, 11'h000, 1, 0, 0, "R3");
    step(0, 11'h000, 0, 0, 1, "R9");                  // R9 data without strobe ignored

    do_reset();                                       // R1, R6 flag cleared only by reset
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[5], lfsr[15:5], lfsr[1] & ~lfsr[6], lfsr[2] & lfsr[3],
           lfsr[4], "R3");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule